// File: doc/BRIEF.md
# Bus-Master DMA Control Register with Transmit Poll Timer

This block is the control register of an Ethernet MAC's bus-master DMA engine, together with the transmit-descriptor poll timer that the register steers. Software writes a single 32-bit word through a plain write port and reads the current settings back on a read bus. The register holds these settings:

- the DMA burst length in bytes
- byte-order flags for transmit and for receive payload
- a test enable
- a software interrupt request
- a global interrupt mask
- a read-only bus-speed status that selects the management clock divider
- a transmit wake-up request that clears itself

The poll timer fires a one-cycle `poll_start` pulse at a programmable interval. Each pulse starts a transmit-descriptor poll. A wake-up request cuts the running interval short, fires a pulse on the next cycle and restarts the timer.

The byte-order flags reach the data path through a registered `swap_bytes` output. This output takes into account whether the current transfer is a descriptor access, because descriptors are always little-endian. Interrupts from outside the block are ORed with the software request and gated by the mask into one registered interrupt line.

Top module: `dma_ctl_reg`

## Requirements
- R1: While reset is high the register reads 0x0000_1020 when `speed_hi` is 0 and 0x0008_1020 when `speed_hi` is 1: burst 32 bytes, wake-up (bit 12) set, speed status (bit 19) equal to `speed_hi`, and all other flags clear.
- R2: A write whose bits 8:2 are not all zero loads the burst field (bits 8:0) with the written bits 8:2 and zeros in bits 1:0. Bits 1:0 always read as zero.
- R3: A write whose bits 8:2 are all zero leaves the burst field unchanged.
- R4: Writing 1 to bit 12 sets the wake-up bit. Writing 0 to bit 12 leaves it unchanged.
- R5: While the wake-up bit is set, the next clock edge raises `poll_start` for one cycle, reloads the poll timer and clears the wake-up bit. A write of 1 to bit 12 on that same edge keeps the bit set.
- R6: Without wake-up, `poll_start` pulses once every `poll_period` cycles. A period of 0 behaves as a period of 1.
- R7: Bit 19 holds the `speed_hi` value captured during reset. Writes do not change it. It drives `clk_div_sel`.
- R8: Bit 13 is a read/write software interrupt request. `irq_out` is registered and goes high one cycle after any `ext_irq` bit or bit 13 is high while the mask is clear.
- R9: While the mask (bit 14) is set, `irq_out` is low on the following cycle whatever the sources. Clearing the mask lets pending sources through again.
- R10: `swap_bytes` is registered. It is 0 after a descriptor access (`xfer_desc`=1). Otherwise it equals bit 11 (transmit big-endian) when `xfer_tx`=1 and bit 10 (receive big-endian) when `xfer_tx`=0.
- R11: Bit 9 is a read/write test enable that drives `test_mode`. Bits 15 to 18 and 20 to 31 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_hi | input | 1 | Bus speed class captured at reset (1 = fast) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| poll_period | input | 16 | Poll interval in cycles |
| ext_irq | input | 4 | External interrupt sources |
| xfer_desc | input | 1 | Current transfer is a descriptor access |
| xfer_tx | input | 1 | Current transfer is transmit-side |
| rd_data | output | 32 | Register read value |
| poll_start | output | 1 | One-cycle poll start pulse |
| irq_out | output | 1 | Masked combined interrupt |
| swap_bytes | output | 1 | Payload byte swap enable |
| test_mode | output | 1 | Test enable |
| clk_div_sel | output | 1 | Management clock divider select |

## Verification
The burst field is written with a normal value, with values that only touch bits 1:0, with all ones and with zero. This shows the difference between filtering and plain storing. Wake-up is requested while the timer is in the middle of an interval, right at its natural end, and together with a write of 0. These cases separate the abort and self-clear paths from the periodic path. Poll periods of 5, 1 and 0 test the reload arithmetic. Interrupts are driven under mask on and mask off, from external and software sources. Swaps are exercised for both directions and for descriptor accesses. A second reset with the fast speed class shows the reset-value choice and that the status bit cannot be written.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  localparam int BURST_MSB = 8;
  localparam int BURST_LSB = 2;
  localparam int BURST_W   = BURST_MSB - BURST_LSB + 1;
  localparam int BIT_TEST  = 9;
  localparam int BIT_RXBE  = 10;
  localparam int BIT_TXBE  = 11;
  localparam int BIT_WAKE  = 12;
  localparam int BIT_SWINT = 13;
  localparam int BIT_MASK  = 14;
  localparam int BIT_SPEED = 19;
  localparam logic [BURST_W-1:0] BURST_RST = BURST_W'(32 >> BURST_LSB);

  typedef struct packed {
    logic [BURST_W-1:0] burst;
    logic               test;
    logic               rxbe;
    logic               txbe;
    logic               wake;
    logic               swint;
    logic               mask;
    logic               speed;
  } ctl_fields_t;
endpackage

// File: rtl/dmactl_fields.sv
module dmactl_fields
  import dmactl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          speed_hi,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wake_ack,
  output ctl_fields_t   fields
);
  logic [BURST_W-1:0] wr_burst;
  logic               wr_burst_ok;
  logic               unused_wr;

  assign wr_burst    = wr_data[BURST_MSB:BURST_LSB];
  assign wr_burst_ok = |wr_burst;
  assign unused_wr   = ^{wr_data[DW-1:BIT_MASK+1], wr_data[BURST_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fields.burst <= BURST_RST;
      fields.test  <= 1'b0;
      fields.rxbe  <= 1'b0;
      fields.txbe  <= 1'b0;
      fields.wake  <= 1'b1;
      fields.swint <= 1'b0;
      fields.mask  <= 1'b0;
      fields.speed <= speed_hi;
    end else begin
      if (wr_en) begin
        if (wr_burst_ok) fields.burst <= wr_burst;
        fields.test  <= wr_data[BIT_TEST];
        fields.rxbe  <= wr_data[BIT_RXBE];
        fields.txbe  <= wr_data[BIT_TXBE];
        fields.swint <= wr_data[BIT_SWINT];
        fields.mask  <= wr_data[BIT_MASK];
      end
      if (wr_en && wr_data[BIT_WAKE]) fields.wake <= 1'b1;
      else if (wake_ack)              fields.wake <= 1'b0;
    end
  end
endmodule

// File: rtl/dmactl_poll.sv
module dmactl_poll #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period,
  input  logic          wake,
  output logic          wake_ack,
  output logic          poll_start
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] reload;
  logic          expire;

  assign reload   = (period == '0) ? '0 : period - PW'(1);
  assign expire   = (cnt == '0);
  assign wake_ack = wake | expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      poll_start <= 1'b0;
    end else if (wake_ack) begin
      cnt        <= reload;
      poll_start <= 1'b1;
    end else begin
      cnt        <= cnt - PW'(1);
      poll_start <= 1'b0;
    end
  end
endmodule

// File: rtl/dmactl_irq.sv
module dmactl_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ext_irq,
  input  logic            swint,
  input  logic            mask,
  output logic            irq_out
);
  logic any_src;
  assign any_src = (|ext_irq) | swint;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= any_src & ~mask;
  end
endmodule

// File: rtl/dmactl_swap.sv
module dmactl_swap (
  input  logic clk,
  input  logic rst,
  input  logic xfer_desc,
  input  logic xfer_tx,
  input  logic txbe,
  input  logic rxbe,
  output logic swap_bytes
);
  logic dir_flag;
  assign dir_flag = xfer_tx ? txbe : rxbe;

  always_ff @(posedge clk) begin
    if (rst) swap_bytes <= 1'b0;
    else     swap_bytes <= dir_flag & ~xfer_desc;
  end
endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dmactl_pkg::*;
#(
  parameter int DW   = 32,
  parameter int PW   = 16,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            speed_hi,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [PW-1:0]   poll_period,
  input  logic [NSRC-1:0] ext_irq,
  input  logic            xfer_desc,
  input  logic            xfer_tx,
  output logic [DW-1:0]   rd_data,
  output logic            poll_start,
  output logic            irq_out,
  output logic            swap_bytes,
  output logic            test_mode,
  output logic            clk_div_sel
);
  ctl_fields_t fields;
  logic        wake_ack;

  dmactl_fields #(.DW(DW)) u_fields (
    .clk(clk), .rst(rst), .speed_hi(speed_hi), .wr_en(wr_en),
    .wr_data(wr_data), .wake_ack(wake_ack), .fields(fields)
  );

  dmactl_poll #(.PW(PW)) u_poll (
    .clk(clk), .rst(rst), .period(poll_period), .wake(fields.wake),
    .wake_ack(wake_ack), .poll_start(poll_start)
  );

  dmactl_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .swint(fields.swint),
    .mask(fields.mask), .irq_out(irq_out)
  );

  dmactl_swap u_swap (
    .clk(clk), .rst(rst), .xfer_desc(xfer_desc), .xfer_tx(xfer_tx),
    .txbe(fields.txbe), .rxbe(fields.rxbe), .swap_bytes(swap_bytes)
  );

  always_comb begin
    rd_data = '0;
    rd_data[BURST_MSB:BURST_LSB] = fields.burst;
    rd_data[BIT_TEST]  = fields.test;
    rd_data[BIT_RXBE]  = fields.rxbe;
    rd_data[BIT_TXBE]  = fields.txbe;
    rd_data[BIT_WAKE]  = fields.wake;
    rd_data[BIT_SWINT] = fields.swint;
    rd_data[BIT_MASK]  = fields.mask;
    rd_data[BIT_SPEED] = fields.speed;
  end

  assign test_mode   = fields.test;
  assign clk_div_sel = fields.speed;
endmodule

// File: rtl/dma_ctl_reg_checker.sv
module dma_ctl_reg_checker #(
  parameter int DW   = 32,
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [DW-1:0]   wr_data,
  input logic            xfer_desc,
  input logic [DW-1:0]   rd_data,
  input logic            poll_start,
  input logic            irq_out,
  input logic            swap_bytes,
  input logic            clk_div_sel
);
  assert_burst_align_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[1:0] == 2'b00 && rd_data[8:2] != 7'd0);

  assert_zero_burst_kept_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[8:2] == 7'd0 |=> $stable(rd_data[8:0]));

  assert_wake_no_self_set_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_data[12] && !(wr_en && wr_data[12]) |=> !rd_data[12]);

  assert_wake_fires_R5: assert property (@(posedge clk) disable iff (rst)
    rd_data[12] && !(wr_en && wr_data[12]) |=> poll_start && !rd_data[12]);

  assert_speed_stable_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(rd_data[19]) && clk_div_sel == rd_data[19]);

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    rd_data[14] |=> !irq_out);

  assert_desc_no_swap_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_desc |=> !swap_bytes);
endmodule

bind dma_ctl_reg dma_ctl_reg_checker #(.DW(DW), .NSRC(NSRC)) u_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .xfer_desc(xfer_desc),
  .rd_data(rd_data), .poll_start(poll_start), .irq_out(irq_out),
  .swap_bytes(swap_bytes), .clk_div_sel(clk_div_sel)
);

// File: tb/dma_ctl_reg_test.sv
module dma_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        speed_hi = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [15:0] poll_period = 16'd5;
  logic [3:0]  ext_irq = '0;
  logic        xfer_desc = 1'b0;
  logic        xfer_tx = 1'b0;
  logic [31:0] rd_data;
  logic        poll_start, irq_out, swap_bytes, test_mode, clk_div_sel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit cmp_on = 0;

  // reference model state
  int m_burst = 32;
  bit m_test, m_rxbe, m_txbe, m_sw, m_mask, m_spd, m_start, m_irq, m_swap;
  bit m_wake = 1;
  bit m_woke;
  int m_cnt = 0;

  dma_ctl_reg uut (
    .clk(clk), .rst(rst), .speed_hi(speed_hi), .wr_en(wr_en), .wr_data(wr_data),
    .poll_period(poll_period), .ext_irq(ext_irq), .xfer_desc(xfer_desc),
    .xfer_tx(xfer_tx), .rd_data(rd_data), .poll_start(poll_start),
    .irq_out(irq_out), .swap_bytes(swap_bytes), .test_mode(test_mode),
    .clk_div_sel(clk_div_sel)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[8:0] = 9'(m_burst);
    w[9] = m_test; w[10] = m_rxbe; w[11] = m_txbe; w[12] = m_wake;
    w[13] = m_sw; w[14] = m_mask; w[19] = m_spd;
    return w;
  endfunction

  always @(posedge clk) begin
    bit fire;
    int rl;
    if (rst) begin
      m_burst = 32; m_test = 0; m_rxbe = 0; m_txbe = 0; m_wake = 1;
      m_sw = 0; m_mask = 0; m_spd = speed_hi; m_cnt = 0; m_start = 0;
      m_irq = 0; m_swap = 0; m_woke = 0;
    end else begin
      fire = m_wake || (m_cnt == 0);
      m_woke = m_wake;
      rl = (poll_period == 0) ? 0 : int'(poll_period) - 1;
      m_start = fire;
      m_cnt = fire ? rl : m_cnt - 1;
      m_irq = !m_mask && (ext_irq != 0 || m_sw);
      m_swap = !xfer_desc && (xfer_tx ? m_txbe : m_rxbe);
      if (wr_en) begin
        if (wr_data[8:2] != 0) m_burst = int'({wr_data[8:2], 2'b00});
        m_test = wr_data[9]; m_rxbe = wr_data[10]; m_txbe = wr_data[11];
        m_sw = wr_data[13]; m_mask = wr_data[14];
      end
      if (wr_en && wr_data[12]) m_wake = 1;
      else if (fire)            m_wake = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check("R2/R3 burst", {23'd0, rd_data[8:0]}, {23'd0, model_word() & 32'h1FF});
      check("R4 wake", {31'd0, rd_data[12]}, {31'd0, m_wake});
      check("R7 speed", {31'd0, clk_div_sel}, {31'd0, m_spd});
      check("R11 word", rd_data, model_word());
      check("R11 test_mode", {31'd0, test_mode}, {31'd0, m_test});
      check(m_woke ? "R5 poll_start" : "R6 poll_start", {31'd0, poll_start}, {31'd0, m_start});
      check(m_mask ? "R9 irq" : "R8 irq", {31'd0, irq_out}, {31'd0, m_irq});
      check("R10 swap", {31'd0, swap_bytes}, {31'd0, m_swap});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic do_reset(bit fast);
    @(negedge clk); rst = 1; speed_hi = fast; cmp_on = 0;
    idle(2);
    // R1: reset value seen while reset is held
    check("R1 reset value", rd_data, fast ? 32'h0008_1020 : 32'h0000_1020);
    check("R1 irq/poll idle", {30'd0, irq_out, poll_start}, 32'd0);
    rst = 0; cmp_on = 1;
  endtask

  initial begin
    do_reset(0);
    idle(12);                       // R6 periodic poll with period 5
    wr(32'h0000_0040);              // R2 burst 64
    idle(3);
    wr(32'h0000_0003);              // R3 only low bits -> ignored
    wr(32'h0000_01FF);              // R2 -> 0x1FC
    wr(32'h0000_0000);              // R3 zero ignored, R4 wake 0 no effect
    idle(2);
    wr(32'h0000_1000);              // R4/R5 wake mid-interval
    idle(7);
    wr(32'h0000_1000);              // wake near natural end
    idle(1);
    wr(32'h0000_1000);
    idle(3);
    wr(32'h0000_0E20);              // R11 test, R10 both flags
    xfer_tx = 1; idle(2);
    xfer_desc = 1; idle(2);         // R10 descriptor never swaps
    xfer_desc = 0; xfer_tx = 0; idle(2);
    wr(32'h0000_0420);              // rx only
    xfer_tx = 1; idle(2); xfer_tx = 0; idle(2);
    ext_irq = 4'b0100; idle(3);     // R8 external
    wr(32'h0000_4020);              // R9 mask on
    idle(3);
    wr(32'h0000_0020);              // mask off, pending passes
    ext_irq = 0; idle(2);
    wr(32'h0000_2020);              // R8 software interrupt
    idle(2);
    wr(32'h0000_6020);              // masked software
    idle(2);
    wr(32'h0008_0020);              // R7 speed not writable
    poll_period = 1; idle(5);       // R6 period 1
    poll_period = 0; idle(5);       // R6 period 0
    poll_period = 3; idle(7);
    do_reset(1);                    // R1 fast class
    idle(3);
    wr(32'h0000_0020);              // R7 write 0 to speed bit
    idle(4);
    wr(32'hFFFF_FFFF);              // R11 unused bits read zero
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule